// File: doc/BRIEF.md
# Dual-Channel Interleaved Converter Output Stage

This block is the digital back end of a two-channel sampling converter. Both channels deliver a 10-bit code, A and B, taken at the same sampling instant. The block delays each pair through a fixed-latency pipeline and then places the two codes one after the other on a single shared 10-bit bus. A goes out in the half of the sample period that starts with the rising edge, and B goes out in the half that follows. A channel flag shows which code is on the bus, and a valid flag marks bus contents that come from a real sample.

The design runs on one internal clock at twice the sample rate. A phase flag, cleared by reset, splits the fast edges into A edges and B edges. The first fast edge after reset is an A edge, and the two kinds alternate from then on. Inputs are captured on A edges.

A format control picks straight offset binary or two's complement on the bus. An output disable control floats the bus and the channel flag. A power-down control freezes every output and discards the samples still in flight. A sleep control stops capture while the pipeline keeps moving.

Top module: `dual_out_stage`

## Requirements
- R1: While reset is high and on the first negative edge after it, `dout` is 0, `is_chan_a` is 0 and `dout_vld` is 0, provided `out_dis` is low.
- R2: Both `samp_a` and `samp_b` are captured on the same A edge. A edges are the fast edges numbered 0, 2, 4, … counting from the first edge after reset is released.
- R3: A code captured on A edge n appears on `dout` after fast edge n+10, which is five sample periods later. At that point `is_chan_a` is 1 and `dout_vld` is 1.
- R4: The B code from the same capture appears after fast edge n+11 with `is_chan_a` at 0. Outside power-down, `is_chan_a` is 1 after each A edge and 0 after each B edge.
- R5: The input codes are offset binary. With `twos_sel` = 0 the bus carries the code unchanged. With `twos_sel` = 1 bit 9 is inverted, so 0x200 becomes 0x000, 0x3FF becomes 0x1FF and 0x000 becomes 0x200. `twos_sel` is applied at the edge where the code is loaded onto the bus.
- R6: While `out_dis` is 1, `dout` and `is_chan_a` are high impedance. While it is 0, both are driven. `out_dis` has no effect on the pipeline or on `dout_vld`.
- R7: On each fast edge where `pwr_dn` is 1, `dout`, `is_chan_a` and `dout_vld` keep their values. The pipeline does not advance, and every sample captured up to and including that edge is discarded.
- R8: On an A edge where `nap` is 1, nothing is captured. The two output slots that the capture would have filled show `dout_vld` = 0 with `dout` unchanged. Valid data returns five sample periods after the first capture following sleep.
- R9: `dout_vld` is 1 after an output slot only if that slot loaded a captured code. Otherwise it is 0, and `dout` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Internal clock at twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| samp_a | input | 10 | Channel A code, offset binary |
| samp_b | input | 10 | Channel B code, offset binary |
| twos_sel | input | 1 | 1 = two's complement output, 0 = offset binary |
| out_dis | input | 1 | 1 floats `dout` and `is_chan_a` |
| pwr_dn | input | 1 | Freeze outputs and flush the pipeline |
| nap | input | 1 | Suspend capture |
| dout | output | 10 | Shared interleaved data bus |
| is_chan_a | output | 1 | 1 while A data is on the bus, 0 while B data is |
| dout_vld | output | 1 | Bus holds a real sample |

## Verification
The main pattern is a vector table. It covers the boundary codes (0x000, 0x1FF, 0x200, 0x3FF), pairs where A and B differ only in bit 9, and values that change in every period. It is run once with the format fixed and once with the format switching between vectors. This separates a correct A/B slot order and a correct ten- or eleven-edge latency from swapped, shifted or mis-formatted data. Sleep windows show that the invalid slots land exactly where the skipped captures would have appeared. A power-down that starts on a B edge shows that the held outputs and the flushed pipeline do not depend on phase. Output-disable windows check the float behaviour without disturbing the data stream that follows.

// File: rtl/dual_out_pkg.sv
package dual_out_pkg;

    localparam int DATA_W = 10;

    typedef logic [DATA_W-1:0] code_t;

    typedef struct packed {
        logic  vld;
        code_t a;
        code_t b;
    } pair_t;

    // offset binary in, selected format out: only the top bit differs
    function automatic code_t fmt_code(input code_t raw, input logic twos);
        code_t r;
        r = raw;
        r[DATA_W-1] = raw[DATA_W-1] ^ twos;
        return r;
    endfunction

endpackage

// File: rtl/phase_gen.sv
module phase_gen (
    input  logic clk,
    input  logic rst,
    output logic ph_q,
    output logic a_edge
);
    // ph_q is 1 during the half that follows an A edge
    always_ff @(posedge clk) begin
        if (rst) ph_q <= 1'b0;
        else     ph_q <= ~ph_q;
    end

    assign a_edge = ~ph_q;
endmodule

// File: rtl/sample_pipe.sv
module sample_pipe
    import dual_out_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  a_edge,
    input  logic  pd,
    input  logic  nap,
    input  code_t in_a,
    input  code_t in_b,
    output pair_t last_q
);
    localparam int NSTG = LAT;

    pair_t stg_q [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q[0] <= '0;
        end else if (pd) begin
            stg_q[0].vld <= 1'b0;
        end else if (a_edge) begin
            stg_q[0] <= '{vld: ~nap, a: in_a, b: in_b};
        end
    end

    for (genvar i = 1; i < NSTG; i++) begin : g_stg
        always_ff @(posedge clk) begin
            if (rst)         stg_q[i] <= '0;
            else if (pd)     stg_q[i].vld <= 1'b0;
            else if (a_edge) stg_q[i] <= stg_q[i-1];
        end
    end

    assign last_q = stg_q[NSTG-1];

    // R8
    nap_chk: assert property (@(posedge clk) disable iff (rst)
        (a_edge && nap) |=> !stg_q[0].vld);
endmodule

// File: rtl/out_mux.sv
module out_mux
    import dual_out_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  a_edge,
    input  logic  pd,
    input  logic  twos,
    input  pair_t last,
    output code_t bus_q,
    output logic  ab_q,
    output logic  vld_q
);
    code_t b_hold_q;
    logic  b_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q    <= '0;
            ab_q     <= 1'b0;
            vld_q    <= 1'b0;
            b_hold_q <= '0;
            b_pend_q <= 1'b0;
        end else if (pd) begin
            b_pend_q <= 1'b0;
        end else begin
            ab_q <= a_edge;
            if (a_edge) begin
                b_pend_q <= last.vld;
                vld_q    <= last.vld;
                if (last.vld) begin
                    bus_q    <= fmt_code(last.a, twos);
                    b_hold_q <= last.b;
                end
            end else begin
                b_pend_q <= 1'b0;
                vld_q    <= b_pend_q;
                if (b_pend_q) bus_q <= fmt_code(b_hold_q, twos);
            end
        end
    end

    // R7
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pd |=> ($stable(bus_q) && $stable(ab_q) && $stable(vld_q)));
    // R9
    inv_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (a_edge && !pd && !last.vld) |=> !vld_q);
    // R5
    fmt_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (a_edge && !pd && last.vld) |=>
            (bus_q[DATA_W-1] == ($past(last.a[DATA_W-1]) ^ $past(twos))));
endmodule

// File: rtl/dual_out_stage.sv
module dual_out_stage
    import dual_out_pkg::*;
#(
    parameter int LAT = 5
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic [DATA_W-1:0] samp_a,
    input  logic [DATA_W-1:0] samp_b,
    input  logic              twos_sel,
    input  logic              out_dis,
    input  logic              pwr_dn,
    input  logic              nap,
    output logic [DATA_W-1:0] dout,
    output logic              is_chan_a,
    output logic              dout_vld
);
    logic  ph_q, a_edge, ab_q;
    pair_t last;
    code_t bus_q;

    phase_gen u_ph (
        .clk(clk_fast), .rst(rst), .ph_q(ph_q), .a_edge(a_edge)
    );

    sample_pipe #(.LAT(LAT)) u_pipe (
        .clk(clk_fast), .rst(rst), .a_edge(a_edge), .pd(pwr_dn), .nap(nap),
        .in_a(samp_a), .in_b(samp_b), .last_q(last)
    );

    out_mux u_mux (
        .clk(clk_fast), .rst(rst), .a_edge(a_edge), .pd(pwr_dn),
        .twos(twos_sel), .last(last), .bus_q(bus_q), .ab_q(ab_q),
        .vld_q(dout_vld)
    );

    assign dout      = out_dis ? 'z : bus_q;
    assign is_chan_a = out_dis ? 1'bz : ab_q;

    // R4
    ab_follow_chk: assert property (@(posedge clk_fast) disable iff (rst)
        !pwr_dn |=> (ab_q == ph_q));
endmodule

// File: tb/dual_out_stage_tb_top.sv
module dual_out_stage_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sa_in = '0, sb_in = '0;
    logic       twos = 1'b0, dis = 1'b0, pd = 1'b0, nap = 1'b0;
    wire  [9:0] dout;
    wire        is_a, vld;

    int checks = 0, fails = 0, e = 0;
    logic [9:0] rec_a [1024];
    logic [9:0] rec_b [1024];
    logic       rec_v [1024];
    logic [9:0] exp_bus = '0;
    logic       exp_ab = 1'b0, exp_vld = 1'b0;

    // {twos, a, b}
    localparam logic [20:0] VEC [12] = '{
        {1'b0, 10'h000, 10'h3FF}, {1'b0, 10'h200, 10'h1FF},
        {1'b0, 10'h3FF, 10'h000}, {1'b0, 10'h155, 10'h2AA},
        {1'b1, 10'h200, 10'h000}, {1'b1, 10'h3FF, 10'h1FF},
        {1'b1, 10'h000, 10'h201}, {1'b1, 10'h1FF, 10'h200},
        {1'b0, 10'h123, 10'h323}, {1'b1, 10'h0F0, 10'h30F},
        {1'b0, 10'h201, 10'h001}, {1'b1, 10'h3C3, 10'h03C}
    };

    dual_out_stage dut_i (
        .clk_fast(clk), .rst(rst), .samp_a(sa_in), .samp_b(sb_in),
        .twos_sel(twos), .out_dis(dis), .pwr_dn(pd), .nap(nap),
        .dout(dout), .is_chan_a(is_a), .dout_vld(vld)
    );

    always #10 clk = ~clk;

    function automatic logic [9:0] fmtc(input logic [9:0] x, input logic t);
        return {x[9] ^ t, x[8:0]};
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s edge %0d: actual %h expected %h", req, e, act, expv);
        end
    endtask

    // one fast edge: update model, clock, compare at the negative edge
    task automatic step(input string req);
        int m;
        m = e;
        if (pd) begin
            for (int k = 0; k <= m; k++) rec_v[k] = 1'b0;
        end else begin
            rec_v[m] = (m % 2 == 0) && !nap;
            rec_a[m] = sa_in;
            rec_b[m] = sb_in;
            exp_ab = (m % 2 == 0);
            if (m % 2 == 0) begin
                exp_vld = (m >= 10) ? rec_v[m-10] : 1'b0;
                if (exp_vld) exp_bus = fmtc(rec_a[m-10], twos);
            end else begin
                exp_vld = (m >= 11) ? rec_v[m-11] : 1'b0;
                if (exp_vld) exp_bus = fmtc(rec_b[m-11], twos);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk({req, " R9 valid"}, {9'd0, vld}, {9'd0, exp_vld});
        if (dis) begin
            chk("R6 float data", dout, 10'bz);
            chk("R6 float flag", {9'd0, is_a}, {9'd0, 1'bz});
        end else begin
            chk({req, " data"}, dout, exp_bus);
            chk({req, " R4 chan flag"}, {9'd0, is_a}, {9'd0, exp_ab});
        end
        e++;
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) rec_v[k] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset data", dout, 10'h000);
        chk("R1 reset flag", {9'd0, is_a}, 10'h000);
        chk("R1 reset valid", {9'd0, vld}, 10'h000);
        rst = 1'b0;
        // R2 R3 R4 R5: table walk, two fast edges per vector
        for (int i = 0; i < 12; i++) begin
            {twos, sa_in, sb_in} = VEC[i];
            step("R3");
            step("R4");
        end
        for (int i = 0; i < 12; i++) begin
            sa_in = 10'(i * 77 + 5);
            sb_in = 10'(i * 131 + 900);
            twos = i[0];
            step("R2");
            step("R5");
        end
        // R8: sleep for three sample periods
        nap = 1'b1;
        for (int i = 0; i < 6; i++) begin sa_in = 10'(i * 9); step("R8"); end
        nap = 1'b0;
        for (int i = 0; i < 16; i++) begin sa_in = 10'(i * 41); sb_in = ~sa_in; step("R8"); end
        // R7: power-down starting on a B edge
        step("R7");
        pd = 1'b1;
        for (int i = 0; i < 6; i++) begin sa_in = 10'(i + 300); step("R7"); end
        pd = 1'b0;
        for (int i = 0; i < 16; i++) begin sa_in = 10'(i * 13); sb_in = 10'(i * 29); step("R7"); end
        // R6: output float window
        dis = 1'b1;
        for (int i = 0; i < 4; i++) step("R6");
        dis = 1'b0;
        for (int i = 0; i < 12; i++) begin sa_in = 10'(i * 3); step("R6"); end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule